// File: doc/BRIEF.md
# Prescaled Timer with Compare Output

An 8-bit up-counter whose count steps are gated by a selectable prescaler. The prescaler is a free-running 10-bit divider. It can be stopped, pass every clock, divide by 8, 64, 256 or 1024, or follow falling or rising edges of an external count pin. The external pin is synchronized inside the block before its edges are used.

Each counting step, the current count is compared with a compare value. On a match the block emits a one-clock match pulse. It also updates a compare output pin according to a 2-bit output mode: off, toggle, force low or force high. An optional clear-on-match control makes the counter restart from zero on the step after it reaches the compare value. That value is therefore held for a full prescale period. Without clear-on-match the counter runs through 0xFF and wraps to 0x00.

All controls are plain input ports, intended to be driven by a register block elsewhere in the chip.

Top module: `cmp_timer`

## Requirements
- R1: While rst_ni is low, and right after it is released, count_o is 0, cmp_pin_o is 0 and match_o is 0. The prescaler and the pin synchronizer restart from 0.
- R2: With clk_sel_i = 3'b000 the count never changes.
- R3: clk_sel_i selects the divide ratio: 3'b001 = every clock, 3'b010 = every 8, 3'b011 = every 64, 3'b100 = every 256, 3'b101 = every 1024 clocks. A counting step happens when the low log2(ratio) bits of the free-running 10-bit prescaler are all ones.
- R4: clk_sel_i = 3'b110 counts falling edges and 3'b111 counts rising edges of ext_pin_i. The pin first passes through a two-stage synchronizer. Each edge gives exactly one step.
- R5: With clr_on_match_i = 0, each step adds 1 modulo 256, so 0xFF is followed by 0x00, and a match does not alter counting.
- R6: With clr_on_match_i = 1, a step taken while count_o equals cmp_val_i loads 0. With divide-by-1 the sequence is C-1, C, 0. With divide-by-8 the value C is held for 8 clocks before 0 appears.
- R7: match_o is high for exactly the clock cycles in which a counting step occurs while count_o equals cmp_val_i.
- R8: On a match, out_mode_i = 2'b01 inverts cmp_pin_o, 2'b10 makes it 0 and 2'b11 makes it 1. The new value appears at the clock edge that ends the match cycle.
- R9: out_mode_i = 2'b00 drives cmp_pin_en_o low and leaves cmp_pin_o unchanged. Any other mode drives cmp_pin_en_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_sel_i | input | 3 | Prescaler source select |
| out_mode_i | input | 2 | Compare output pin mode |
| clr_on_match_i | input | 1 | Restart count from zero after a match |
| cmp_val_i | input | 8 | Compare value |
| ext_pin_i | input | 1 | External count pin (asynchronous) |
| count_o | output | 8 | Current count |
| cmp_pin_o | output | 1 | Compare output pin value |
| cmp_pin_en_o | output | 1 | Compare output pin is connected to the timer |
| match_o | output | 1 | One-cycle compare match pulse |

## Verification
The assertions treat clk_sel_i, out_mode_i, clr_on_match_i and cmp_val_i as software-written fields that may change on any clock. The one property that depends on the selection, single-step-per-edge in the external modes, is therefore waived on a clock where clk_sel_i has just changed. The external pin is assumed to be sampled slowly compared with the clock, so that every level lasts at least two clocks. The stimulus holds each pin level for three clocks and changes control fields only in the middle of a clock period. The behavioural model follows every such change.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    CS_STOP     = 3'd0,
    CS_DIV1     = 3'd1,
    CS_DIV8     = 3'd2,
    CS_DIV64    = 3'd3,
    CS_DIV256   = 3'd4,
    CS_DIV1024  = 3'd5,
    CS_EXT_FALL = 3'd6,
    CS_EXT_RISE = 3'd7
  } clk_sel_e;

  typedef enum logic [1:0] {
    OM_OFF    = 2'd0,
    OM_TOGGLE = 2'd1,
    OM_CLEAR  = 2'd2,
    OM_SET    = 2'd3
  } out_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int PRE_W   = 10,
  parameter int SYNC_ST = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] clk_sel_i,
  input  logic       ext_pin_i,
  output logic       tick_o
);
  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  logic [PRE_W-1:0]   pre_q;
  logic [SYNC_ST-1:0] sync_q;
  logic               last_q;
  logic [PRE_W-1:0]   mask;
  logic               div_hit, ext_s;
  clk_sel_e           sel;

  assign sel   = clk_sel_e'(clk_sel_i);
  assign ext_s = sync_q[SYNC_ST-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      pre_q  <= pre_q + ONE;
      sync_q <= {sync_q[SYNC_ST-2:0], ext_pin_i};
      last_q <= ext_s;
    end
  end

  always_comb begin
    unique case (sel)
      CS_DIV8:    mask = (ONE << 3) - ONE;
      CS_DIV64:   mask = (ONE << 6) - ONE;
      CS_DIV256:  mask = (ONE << 8) - ONE;
      CS_DIV1024: mask = '1;
      default:    mask = '0;
    endcase
  end

  assign div_hit = (pre_q & mask) == mask;

  always_comb begin
    unique case (sel)
      CS_STOP:     tick_o = 1'b0;
      CS_EXT_FALL: tick_o = last_q & ~ext_s;
      CS_EXT_RISE: tick_o = ~last_q & ext_s;
      default:     tick_o = div_hit;
    endcase
  end

  // R4: one step per edge, unless the selection just changed
  assert_one_tick_per_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && clk_sel_i[2:1] == 2'b11) |=> (!tick_o || clk_sel_i != $past(clk_sel_i)));

  // R2: stop never steps
  assert_stop_no_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == CS_STOP) |-> !tick_o);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_on_match_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             eq;

  assign eq      = cnt_q == cmp_val_i;
  assign match_o = tick_i & eq;
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (tick_i) begin
      if (clr_on_match_i && eq)     cnt_q <= '0;
      else                          cnt_q <= cnt_q + ONE;
    end
  end

  assert_hold_without_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));

  assert_clear_after_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && clr_on_match_i && cnt_q == cmp_val_i) |=> cnt_q == '0);

  assert_step_or_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !(clr_on_match_i && cnt_q == cmp_val_i)) |=> cnt_q == CNT_W'($past(cnt_q) + ONE));
endmodule

// File: rtl/tmr_cmp_out.sv
module tmr_cmp_out
  import tmr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       match_i,
  input  logic [1:0] out_mode_i,
  output logic       pin_o,
  output logic       pin_en_o
);
  out_mode_e mode;
  logic      pin_q, pin_d;

  assign mode     = out_mode_e'(out_mode_i);
  assign pin_en_o = mode != OM_OFF;
  assign pin_o    = pin_q;

  always_comb begin
    pin_d = pin_q;
    if (match_i) begin
      unique case (mode)
        OM_TOGGLE: pin_d = ~pin_q;
        OM_CLEAR:  pin_d = 1'b0;
        OM_SET:    pin_d = 1'b1;
        default:   pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assert_toggle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode == OM_TOGGLE) |=> pin_q != $past(pin_q));

  assert_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode == OM_SET) |=> pin_q);

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_i && mode == OM_CLEAR) |=> !pin_q);

  assert_off_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_i || mode == OM_OFF) |=> $stable(pin_q));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       clk_sel_i,
  input  logic [1:0]       out_mode_i,
  input  logic             clr_on_match_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  input  logic             ext_pin_i,
  output logic [CNT_W-1:0] count_o,
  output logic             cmp_pin_o,
  output logic             cmp_pin_en_o,
  output logic             match_o
);
  logic tick, match;

  tmr_prescaler #(.PRE_W(PRE_W), .SYNC_ST(2)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_sel_i (clk_sel_i),
    .ext_pin_i (ext_pin_i),
    .tick_o    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tick_i         (tick),
    .clr_on_match_i (clr_on_match_i),
    .cmp_val_i      (cmp_val_i),
    .count_o        (count_o),
    .match_o        (match)
  );

  tmr_cmp_out u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .match_i    (match),
    .out_mode_i (out_mode_i),
    .pin_o      (cmp_pin_o),
    .pin_en_o   (cmp_pin_en_o)
  );

  assign match_o = match;
endmodule

// File: tb/cmp_timer_tb.sv
`timescale 1ns/1ps
module cmp_timer_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [1:0] mode = 2'd0;
  logic       ctc = 1'b0;
  logic [7:0] cmp = 8'd0;
  logic       ext = 1'b1;
  logic [7:0] count;
  logic       pin, pin_en, match;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit live   = 1'b0;

  // behavioural model state
  int m_pre, m_cnt;
  bit m_s1, m_s2, m_s3, m_pin;

  always #2.5 clk = ~clk;

  cmp_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_sel_i(sel), .out_mode_i(mode),
    .clr_on_match_i(ctc), .cmp_val_i(cmp), .ext_pin_i(ext),
    .count_o(count), .cmp_pin_o(pin), .cmp_pin_en_o(pin_en), .match_o(match)
  );

  function automatic bit m_tick();
    case (sel)
      3'd1: return 1'b1;
      3'd2: return (m_pre % 8) == 7;
      3'd3: return (m_pre % 64) == 63;
      3'd4: return (m_pre % 256) == 255;
      3'd5: return m_pre == 1023;
      3'd6: return m_s3 && !m_s2;
      3'd7: return !m_s3 && m_s2;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_match();
    return m_tick() && (m_cnt == int'(cmp));
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_pin = 0;
    end else begin
      bit t, mt;
      t  = m_tick();
      mt = m_match();
      if (mt) begin
        if (mode == 2'd1) m_pin = !m_pin;
        else if (mode == 2'd2) m_pin = 1'b0;
        else if (mode == 2'd3) m_pin = 1'b1;
      end
      if (t) m_cnt = (ctc && m_cnt == int'(cmp)) ? 0 : (m_cnt + 1) % 256;
      m_pre = (m_pre + 1) % 1024;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (live) begin
      chk(int'(count) == m_cnt, "R3 R5 R6 count", int'(count), m_cnt);
      chk(match == m_match(), "R7 match", int'(match), int'(m_match()));
      chk(pin == m_pin, "R8 pin", int'(pin), int'(m_pin));
      chk(pin_en == (mode != 2'd0), "R9 pin_en", int'(pin_en), int'(mode != 2'd0));
    end
    if (cycles >= 200000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(); #1; endtask

  task automatic wait_change(output bit ok);
    logic [7:0] prev;
    ok = 1'b0;
    prev = count;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (count != prev) begin ok = 1'b1; break; end
    end
  endtask

  task automatic wait_match();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (match) break;
    end
  endtask

  task automatic interval(input logic [2:0] s, input int n);
    bit ok;
    int k;
    @(negedge clk); drive();
    sel = s; ctc = 1'b0;
    wait_change(ok);
    k = 0;
    begin
      logic [7:0] prev;
      prev = count;
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        k++;
        if (count != prev) break;
      end
    end
    chk(k == n, "R3 step interval", k, n);
  endtask

  initial begin
    // R1: reset state
    cyc(3);
    chk(count == 8'd0 && pin == 1'b0 && match == 1'b0, "R1 in reset", int'(count), 0);
    drive(); rst_ni = 1'b1;
    live = 1'b1;
    @(negedge clk);
    chk(count == 8'd0 && pin == 1'b0, "R1 after release", int'(count), 0);

    // R2: stopped
    cyc(20);
    chk(count == 8'd0, "R2 stop holds", int'(count), 0);

    // R5: div1 free run with wrap, toggle mode
    drive(); sel = 3'd1; mode = 2'd1; cmp = 8'd5;
    cyc(300);

    // R6/R7: clear on match, div1, C=10
    drive(); ctc = 1'b1; cmp = 8'd10;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (count == 8'd9) break; end
    chk(!match, "R7 no match at C-1", int'(match), 0);
    @(negedge clk);
    chk(count == 8'd10, "R6 C follows C-1", int'(count), 10);
    chk(match, "R7 match at C", int'(match), 1);
    @(negedge clk);
    chk(count == 8'd0, "R6 zero after C", int'(count), 0);

    // R6: div8, C=3 held 8 clocks
    drive(); sel = 3'd2; cmp = 8'd3;
    begin
      logic [7:0] prev;
      int held;
      prev = count;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (count == 8'd3 && prev == 8'd2) break;
        prev = count;
      end
      held = 1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (count != 8'd3) break;
        held++;
      end
      chk(held == 8, "R6 C held for div8", held, 8);
      chk(count == 8'd0, "R6 zero after held C", int'(count), 0);
    end

    // R3: divide ratios
    interval(3'd1, 1);
    interval(3'd2, 8);
    interval(3'd3, 64);
    interval(3'd4, 256);
    interval(3'd5, 1024);

    // R4: falling then rising edges of the external pin
    drive(); sel = 3'd6; ctc = 1'b0; ext = 1'b1;
    cyc(6);
    begin
      int c0;
      c0 = int'(count);
      for (int p = 0; p < 5; p++) begin
        drive(); ext = 1'b0; cyc(3);
        drive(); ext = 1'b1; cyc(3);
      end
      cyc(4);
      chk(int'(count) == (c0 + 5) % 256, "R4 falling edges", int'(count), (c0 + 5) % 256);
      drive(); sel = 3'd7;
      cyc(2);
      c0 = int'(count);
      for (int p = 0; p < 7; p++) begin
        drive(); ext = 1'b0; cyc(3);
        drive(); ext = 1'b1; cyc(3);
      end
      cyc(4);
      chk(int'(count) == (c0 + 7) % 256, "R4 rising edges", int'(count), (c0 + 7) % 256);
    end

    // R8/R9: pin modes with div1, clear on match at 3
    drive(); sel = 3'd1; ctc = 1'b1; cmp = 8'd3; mode = 2'd3;
    wait_match(); @(negedge clk);
    chk(pin == 1'b1, "R8 set mode", int'(pin), 1);
    drive(); mode = 2'd2;
    wait_match(); @(negedge clk);
    chk(pin == 1'b0, "R8 clear mode", int'(pin), 0);
    drive(); mode = 2'd1;
    wait_match(); @(negedge clk);
    chk(pin == 1'b1, "R8 toggle mode", int'(pin), 1);
    wait_match(); @(negedge clk);
    chk(pin == 1'b0, "R8 toggle again", int'(pin), 0);
    drive(); mode = 2'd3;
    wait_match(); @(negedge clk);
    drive(); mode = 2'd0;
    cyc(20);
    chk(pin == 1'b1 && pin_en == 1'b0, "R9 off keeps pin", int'(pin), 1);

    // R1: reset mid-run
    drive(); rst_ni = 1'b0;
    @(negedge clk);
    chk(count == 8'd0 && pin == 1'b0, "R1 reset mid-run", int'(count), 0);
    drive(); rst_ni = 1'b1;
    cyc(10);

    live = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule